// File: doc/BRIEF.md
# Sector Decode Interrupt Controller

This block holds the interrupt and status state of an error-correction decode engine that works through a page one sector at a time. The decoder sends a one-cycle pulse, with the index of the sector, each time a sector finishes. The block records the finished sectors in a bitmask and keeps one pending decode-status flag. It drives a single active-low interrupt line from that flag, gated by an interrupt enable.

Software reaches the block through a small register port with four word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 written as 1 starts a new operation; bit 1 selects page mode |
| 1 | enable | bit 0 is the decode interrupt enable |
| 2 | status | bit 0 is the pending flag; reading clears it |
| 3 | done mask | one bit per finished sector |

Reading the status register returns the pending flag and clears it, but only while the enable is set. In per-sector mode every completion raises the flag again, including a completion that lands just after a read has cleared it. Page mode raises the flag only when the last sector of the page completes. This prevents the burst of extra interrupts that per-sector signalling causes. Software polls the done mask against the expected set of sectors to see how far the page has progressed.

Top module: `decode_irq_ctrl`

## Requirements
- R1: After reset, the done mask reads 0, the status reads 0, the enable reads 0, the control register reads 0, and irq_n is 1.
- R2: In per-sector mode (control bit 1 = 0), each accepted sector completion sets the pending flag. With the enable at 1, irq_n is 0 from the cycle after the pulse.
- R3: A completion with index i below NSEC sets bit i of the done mask (address 3). Bits at NSEC and above always read 0. A completion with index NSEC or higher changes neither the mask nor the pending flag.
- R4: A read of address 2 returns the pending flag in bit 0 on the cycle after the read strobe. While the enable is 1, that read clears the flag, so irq_n returns to 1.
- R5: A status read while the enable is 0 leaves the pending flag unchanged, and a later read still sees it.
- R6: If a sector completion and a status read fall in the same cycle, the completion wins: the flag stays set after the read, and the read returns the value held before that cycle.
- R7: A completion that arrives after a status read has cleared the flag sets the flag again and drives irq_n back to 0.
- R8: In page mode (control bit 1 = 1), the flag is set only by a completion after which all NSEC low mask bits are 1. Earlier completions leave irq_n at 1. Address 0 reads back the mode in bit 1.
- R9: Writing control with bit 0 = 1 clears the done mask and the pending flag. This takes priority over a sector completion in the same cycle.
- R10: While the enable is 0, irq_n is 1 and any pending flag is kept. Setting the enable to 1 with the flag set drives irq_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_done | input | 1 | One-cycle pulse when a sector finishes decoding |
| sec_idx | input | 4 | Index of the finished sector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| irq_n | output | 1 | Active-low decode interrupt |

## Verification
The per-sector path is driven in three ways: with isolated pulses, each cleared by a read before the next; with pulses left to pile up under one pending flag; and with a pulse placed in the same cycle as the clearing read. Together these separate a clear that loses to a completion from one that wins. Page mode is run through every sector index in turn, which shows whether the line fires on the final sector only or earlier. Reads with the enable off and out-of-range indices confirm that these leave state untouched. A start write coinciding with a pulse confirms which of the two takes priority.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;
  localparam int DONE_W = 16;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_EN   = 2'd1,
    A_STAT = 2'd2,
    A_DONE = 2'd3
  } reg_addr_e;

  // Bits below n set, the rest clear.
  function automatic logic [DONE_W-1:0] low_mask(int unsigned n);
    logic [DONE_W-1:0] m;
    for (int i = 0; i < DONE_W; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [DONE_W-1:0] sector_bit(logic [IDX_W-1:0] idx);
    return DONE_W'(1) << idx;
  endfunction
endpackage

// File: rtl/dec_sector_track.sv
module dec_sector_track
  import dec_irq_pkg::*;
#(
  parameter int unsigned NSEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sec_done,
  input  logic [IDX_W-1:0]  sec_idx,
  output logic [DONE_W-1:0] done_mask,
  output logic              idx_ok,
  output logic              page_full_next
);
  localparam logic [DONE_W-1:0] FULL = low_mask(NSEC);

  logic [DONE_W-1:0] done_q;
  logic [DONE_W-1:0] mask_nxt;

  assign idx_ok   = (32'(sec_idx) < NSEC);
  assign mask_nxt = done_q | ((sec_done && idx_ok) ? sector_bit(sec_idx) : '0);
  assign page_full_next = ((mask_nxt & FULL) == FULL);
  assign done_mask = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_q <= '0;
    else if (start) done_q <= '0;
    else            done_q <= mask_nxt & FULL;
  end

  // R9: a start empties the mask
  p_start_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (done_mask == '0));
  // R3: without a start, sectors are never forgotten
  p_mask_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((done_mask & $past(done_mask)) == $past(done_mask)));
  // R3: an out-of-range index leaves the mask alone
  p_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && sec_done && !idx_ok) |=> $stable(done_mask));
endmodule

// File: rtl/dec_irq_status.sv
module dec_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic page_mode,
  input  logic sec_ok,
  input  logic page_full_next,
  input  logic stat_rd,
  input  logic irq_en,
  output logic stat_q,
  output logic sector_event,
  output logic clear_ok,
  output logic irq_n
);
  assign sector_event = sec_ok && (!page_mode || page_full_next);
  assign clear_ok     = stat_rd && irq_en;
  assign irq_n        = ~(stat_q & irq_en);

  // Priority: start, then completion, then clear-on-read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stat_q <= 1'b0;
    else if (start)        stat_q <= 1'b0;
    else if (sector_event) stat_q <= 1'b1;
    else if (clear_ok)     stat_q <= 1'b0;
  end

  // R2: a per-sector completion raises the flag
  p_sector_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_ok && !page_mode && !start) |=> stat_q);
  // R4: an enabled read with no competing event clears the flag
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && irq_en && !sec_ok && !start) |=> !stat_q);
  // R5: a read with the enable off changes nothing
  p_masked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_en && !sec_ok && !start) |=> $stable(stat_q));
  // R6: completion beats a same-cycle read in per-sector mode
  p_race_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && sec_ok && !page_mode && !start) |=> stat_q);
  // R8: in page mode a partial page never raises the flag
  p_page_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_mode && !stat_q && !page_full_next && !start) |=> !stat_q);
endmodule

// File: rtl/dec_reg_port.sv
module dec_reg_port
  import dec_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              stat_q,
  input  logic [DONE_W-1:0] done_mask,
  output logic              start,
  output logic              page_mode,
  output logic              irq_en,
  output logic              stat_rd,
  output logic [15:0]       reg_rdata
);
  reg_addr_e a;
  logic [15:0] rd_mux;

  assign a       = reg_addr_e'(reg_addr);
  assign start   = reg_wr && (a == A_CTRL) && reg_wdata[0];
  assign stat_rd = reg_rd && (a == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_mode <= 1'b0;
      irq_en    <= 1'b0;
    end else if (reg_wr) begin
      if (a == A_CTRL) page_mode <= reg_wdata[1];
      if (a == A_EN)   irq_en    <= reg_wdata[0];
    end
  end

  always_comb begin
    unique case (a)
      A_CTRL:  rd_mux = {14'd0, page_mode, 1'b0};
      A_EN:    rd_mux = {15'd0, irq_en};
      A_STAT:  rd_mux = {15'd0, stat_q};
      default: rd_mux = 16'(done_mask);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R4: a status read returns the flag as it stood in the read cycle
  p_stat_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (reg_rdata == {15'd0, $past(stat_q)}));
endmodule

// File: rtl/decode_irq_ctrl.sv
module decode_irq_ctrl
  import dec_irq_pkg::*;
#(
  parameter int unsigned NSEC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_done,
  input  logic [3:0]  sec_idx,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_n
);
  logic              start, page_mode, irq_en, stat_rd, stat_q;
  logic              idx_ok, page_full_next, sector_event, clear_ok;
  logic [DONE_W-1:0] done_mask;

  dec_reg_port u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_q(stat_q),
    .done_mask(done_mask), .start(start), .page_mode(page_mode),
    .irq_en(irq_en), .stat_rd(stat_rd), .reg_rdata(reg_rdata)
  );

  dec_sector_track #(.NSEC(NSEC)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .sec_done(sec_done),
    .sec_idx(sec_idx), .done_mask(done_mask), .idx_ok(idx_ok),
    .page_full_next(page_full_next)
  );

  dec_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
    .sec_ok(sec_done && idx_ok), .page_full_next(page_full_next),
    .stat_rd(stat_rd), .irq_en(irq_en), .stat_q(stat_q),
    .sector_event(sector_event), .clear_ok(clear_ok), .irq_n(irq_n)
  );

  // R10: the enable being off holds the line high
  p_line_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);
  // R7: a completion on an enabled line pulls it low next cycle
  p_reassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_event && !start && irq_en && !(reg_wr && reg_addr == 2'd1)) |=> !irq_n);
  // R9: start wins over a same-cycle completion
  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> irq_n);
endmodule

// File: tb/decode_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module decode_irq_ctrl_tb_top;
  localparam int unsigned NSEC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_done = 1'b0;
  logic [3:0]  sec_idx = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  decode_irq_ctrl #(.NSEC(NSEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_done(sec_done), .sec_idx(sec_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [3:0] idx);
    sec_done = 1'b1; sec_idx = idx;
    @(negedge clk);
    sec_done = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 irq_n", 16'(irq_n), 16'h1);
    rd(2'd3, d); chk("R1 done mask", d, 16'h0);
    rd(2'd2, d); chk("R1 status", d, 16'h0);
    rd(2'd1, d); chk("R1 enable", d, 16'h0);
    rd(2'd0, d); chk("R1 control", d, 16'h0);
  endtask

  task automatic t_per_sector;
    logic [15:0] d;
    wr(2'd1, 16'h1);
    wr(2'd0, 16'h1);
    pulse(4'd0);
    chk("R2 irq low after sector", 16'(irq_n), 16'h0);
    rd(2'd2, d); chk("R4 status returns pending", d, 16'h1);
    chk("R4 irq high after read", 16'(irq_n), 16'h1);
    rd(2'd2, d); chk("R4 status cleared", d, 16'h0);
    pulse(4'd1);
    chk("R7 irq reasserted", 16'(irq_n), 16'h0);
    pulse(4'd2);
    rd(2'd3, d); chk("R3 done mask bits", d, 16'h0007);
    rd(2'd2, d); chk("R2 status pending", d, 16'h1);
  endtask

  task automatic t_bounds;
    logic [15:0] d;
    pulse(4'd10);
    chk("R3 bad index no irq", 16'(irq_n), 16'h1);
    rd(2'd3, d); chk("R3 bad index mask", d, 16'h0007);
    rd(2'd2, d); chk("R3 bad index status", d, 16'h0);
  endtask

  task automatic t_masked;
    logic [15:0] d;
    wr(2'd1, 16'h0);
    pulse(4'd3);
    chk("R10 masked line high", 16'(irq_n), 16'h1);
    rd(2'd2, d); chk("R5 masked read value", d, 16'h1);
    rd(2'd2, d); chk("R5 masked read kept", d, 16'h1);
    wr(2'd1, 16'h1);
    chk("R10 re-enable drives low", 16'(irq_n), 16'h0);
    rd(2'd2, d); chk("R4 read after enable", d, 16'h1);
    chk("R4 line released", 16'(irq_n), 16'h1);
  endtask

  task automatic t_race;
    logic [15:0] d;
    reg_rd = 1'b1; reg_addr = 2'd2; sec_done = 1'b1; sec_idx = 4'd4;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0; sec_done = 1'b0;
    chk("R6 race read returns old", d, 16'h0);
    chk("R6 race line low", 16'(irq_n), 16'h0);
    rd(2'd2, d); chk("R6 race flag kept", d, 16'h1);
  endtask

  task automatic t_page;
    logic [15:0] d;
    wr(2'd0, 16'h3);
    rd(2'd0, d); chk("R8 mode readback", d, 16'h2);
    rd(2'd3, d); chk("R9 start clears mask", d, 16'h0);
    for (int i = 0; i < int'(NSEC) - 1; i++) begin
      pulse(4'(i));
      chk("R8 no irq before last", 16'(irq_n), 16'h1);
    end
    pulse(4'(NSEC - 1));
    chk("R8 irq on last sector", 16'(irq_n), 16'h0);
    rd(2'd2, d); chk("R8 status set", d, 16'h1);
    rd(2'd3, d); chk("R8 full mask", d, 16'h00FF);
  endtask

  task automatic t_start;
    logic [15:0] d;
    wr(2'd0, 16'h1);
    pulse(4'd2);
    chk("R2 pending before start", 16'(irq_n), 16'h0);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h1;
    sec_done = 1'b1; sec_idx = 4'd5;
    @(negedge clk);
    reg_wr = 1'b0; sec_done = 1'b0;
    chk("R9 start wins line", 16'(irq_n), 16'h1);
    rd(2'd3, d); chk("R9 start wins mask", d, 16'h0);
    rd(2'd2, d); chk("R9 start wins status", d, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_per_sector();
    t_bounds();
    t_masked();
    t_race();
    t_page();
    t_start();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule